// File: doc/BRIEF.md
# Floating-Point Control Register Transfer Decoder

This block decodes the coprocessor instruction that copies one floating-point control register to an integer register, or copies an integer register into one. It takes the instruction's opcode word, the extension word that follows it, a qualifier strobe and a model-select input. One cycle after a qualified instruction it issues one of three results: a read strobe, which copies a floating-point control register out to an integer register; a write strobe, which loads a floating-point control register from an integer register; or a trap pulse, which marks the instruction as unimplemented. While a strobe is high, the decoder also reports which control register is involved, whether the integer operand is a data or an address register, and that register's number.

The block also checks the addressing mode of the floating-point data-register-list move. It traps the two modes that this form does not support and lets every other list move pass without issuing anything. The model-select input switches on the behaviour of the later processor generation. That generation differs in two cases: a data-register move that selects several registers, and an address-register move that selects none.

Top module: `fpu_ctl_xfer_dec`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `rd_stb`, `wr_stb`, `trap`, `sel`, `to_int`, `is_areg` and `reg_num` are all zero.
- R2: Results appear on the cycle after `in_valid` and last one cycle only. With `in_valid` low, every output stays zero.
- R3: Extension bits 12, 11 and 10 select the control, status and instruction-address register. `sel` reports the selection one-hot: bit 2 for control, bit 1 for status, bit 0 for instruction address. Opcode bits 5:3 set to 000 mean a data register and 001 an address register, and `is_areg` is 1 for an address register. Opcode bits 2:0 appear on `reg_num`.
- R4: Extension bits 15:14 = 10 mark a control register move. Extension bit 13 set gives `rd_stb` with `to_int`=1, meaning a copy out to the integer register. Bit 13 clear gives `wr_stb` with `to_int`=0.
- R5: A control register move with a data register and all three selection bits clear transfers the instruction-address register (`sel`=001).
- R6: A data register move with more than one selection bit set raises `trap` when `late_model` is 0.
- R7: A data register move with more than one selection bit set produces no strobe and no trap when `late_model` is 1.
- R8: An address register move with extension bit 12 or bit 11 set raises `trap` in both models. With only bit 10 set, it transfers the instruction-address register.
- R9: An address register move with all selection bits clear transfers the instruction-address register when `late_model` is 0, and raises `trap` when `late_model` is 1.
- R10: For a list move (extension bits 15:14 = 11), bit 13 set with mode 011 (postincrement) traps, and bit 13 clear with mode 100 (predecrement) traps. Every other list move produces no output.
- R11: `late_model` is sampled in the same cycle as `in_valid`. Changing it afterwards does not alter the result.
- R12: At most one of `rd_stb`, `wr_stb` and `trap` is high in any cycle. While `trap` is high or no strobe is high, `sel`, `to_int`, `is_areg` and `reg_num` are zero.
- R13: Extension bits 15:14 of 00 or 01 produce no output. So does a control register move whose mode is neither 000 nor 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies opcode, extension word and model select |
| opcode | input | 16 | Instruction opcode word |
| ext_word | input | 16 | Instruction extension word |
| late_model | input | 1 | 1 selects the later-generation behaviour |
| rd_stb | output | 1 | Copy the control register out to the integer register |
| wr_stb | output | 1 | Load the control register from the integer register |
| trap | output | 1 | Unimplemented-instruction trap pulse |
| sel | output | 3 | One-hot control register selection {control, status, instr-address} |
| to_int | output | 1 | Transfer direction, 1 = toward the integer register |
| is_areg | output | 1 | Integer operand is an address register |
| reg_num | output | 3 | Integer register number |

## Verification
The assertions rely on the upstream stage holding the opcode, extension word and model select steady only within the cycle in which `in_valid` is high. They also rely on reset lasting at least one clock edge. Given that, every output pulse can be traced back to a qualified instruction. The bench drives all inputs on the falling edge and raises `in_valid` for exactly one cycle per instruction. It also toggles `late_model` only after the sampling edge, so it stays within these conditions while still showing that the quirks depend on the sampled value.

// File: rtl/fpu_xfer_pkg.sv
package fpu_xfer_pkg;
  localparam int SEL_W    = 3;
  localparam int REGNUM_W = 3;

  typedef enum logic [2:0] {
    EA_DREG,
    EA_AREG,
    EA_POSTINC,
    EA_PREDEC,
    EA_OTHER
  } ea_kind_t;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_CTLREG,
    CLS_LIST
  } xfer_cls_t;

  typedef struct packed {
    logic                rd;
    logic                wr;
    logic                trap;
    logic [SEL_W-1:0]    sel;
    logic                to_int;
    logic                areg;
    logic [REGNUM_W-1:0] num;
  } xfer_res_t;
endpackage

// File: rtl/fpu_ea_class.sv
module fpu_ea_class
  import fpu_xfer_pkg::*;
(
  input  logic [5:0]          mode_reg,
  output ea_kind_t            kind,
  output logic [REGNUM_W-1:0] num
);
  always_comb begin
    unique case (mode_reg[5:3])
      3'b000:  kind = EA_DREG;
      3'b001:  kind = EA_AREG;
      3'b011:  kind = EA_POSTINC;
      3'b100:  kind = EA_PREDEC;
      default: kind = EA_OTHER;
    endcase
  end

  assign num = mode_reg[REGNUM_W-1:0];
endmodule

// File: rtl/fpu_sel_norm.sv
module fpu_sel_norm
  import fpu_xfer_pkg::*;
(
  input  logic [SEL_W-1:0] raw_sel,
  output logic [SEL_W-1:0] eff_sel,
  output logic             multi,
  output logic             empty
);
  localparam logic [SEL_W-1:0] IADDR_ONLY = SEL_W'(1);

  logic [$clog2(SEL_W+1)-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < SEL_W; i++) cnt = cnt + raw_sel[i];
  end

  assign empty   = (cnt == 0);
  assign multi   = (cnt > 1);
  assign eff_sel = empty ? IADDR_ONLY : raw_sel;
endmodule

// File: rtl/fpu_xfer_rules.sv
module fpu_xfer_rules
  import fpu_xfer_pkg::*;
(
  input  xfer_cls_t           cls,
  input  ea_kind_t            kind,
  input  logic [REGNUM_W-1:0] num,
  input  logic                dir_out,
  input  logic                late,
  input  logic [SEL_W-1:0]    raw_sel,
  input  logic [SEL_W-1:0]    eff_sel,
  input  logic                multi,
  input  logic                empty,
  output xfer_res_t           res
);
  logic go;
  logic ctl_or_stat;

  assign ctl_or_stat = |raw_sel[SEL_W-1:1];

  always_comb begin
    res = '0;
    go  = 1'b0;
    unique case (cls)
      CLS_CTLREG: begin
        if (kind == EA_DREG) begin
          if (multi) res.trap = !late;
          else       go = 1'b1;
        end else if (kind == EA_AREG) begin
          if (ctl_or_stat)        res.trap = 1'b1;
          else if (empty && late) res.trap = 1'b1;
          else                    go = 1'b1;
        end
      end
      CLS_LIST: begin
        if (dir_out && kind == EA_POSTINC)  res.trap = 1'b1;
        if (!dir_out && kind == EA_PREDEC)  res.trap = 1'b1;
      end
      default: ;
    endcase
    if (go) begin
      res.rd     = dir_out;
      res.wr     = !dir_out;
      res.sel    = eff_sel;
      res.to_int = dir_out;
      res.areg   = (kind == EA_AREG);
      res.num    = num;
    end
  end
endmodule

// File: rtl/fpu_ctl_xfer_dec.sv
module fpu_ctl_xfer_dec
  import fpu_xfer_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     opcode,
  input  logic [EXT_W-1:0]    ext_word,
  input  logic                late_model,
  output logic                rd_stb,
  output logic                wr_stb,
  output logic                trap,
  output logic [SEL_W-1:0]    sel,
  output logic                to_int,
  output logic                is_areg,
  output logic [REGNUM_W-1:0] reg_num
);
  localparam int CLS_HI  = EXT_W - 1;
  localparam int DIR_BIT = EXT_W - 3;
  localparam int SEL_HI  = EXT_W - 4;
  localparam int SEL_LO  = SEL_HI - SEL_W + 1;

  xfer_cls_t           cls;
  ea_kind_t            kind;
  logic [REGNUM_W-1:0] num;
  logic [SEL_W-1:0]    eff_sel;
  logic                multi, empty;
  xfer_res_t           res_d, res_q;
  logic                unused_bits;

  assign unused_bits = ^{opcode[OP_W-1:6], ext_word[SEL_LO-1:0]};

  always_comb begin
    unique case (ext_word[CLS_HI -: 2])
      2'b10:   cls = CLS_CTLREG;
      2'b11:   cls = CLS_LIST;
      default: cls = CLS_NONE;
    endcase
  end

  fpu_ea_class u_ea (
    .mode_reg (opcode[5:0]),
    .kind     (kind),
    .num      (num)
  );

  fpu_sel_norm u_sel (
    .raw_sel (ext_word[SEL_HI:SEL_LO]),
    .eff_sel (eff_sel),
    .multi   (multi),
    .empty   (empty)
  );

  fpu_xfer_rules u_rules (
    .cls     (cls),
    .kind    (kind),
    .num     (num),
    .dir_out (ext_word[DIR_BIT]),
    .late    (late_model),
    .raw_sel (ext_word[SEL_HI:SEL_LO]),
    .eff_sel (eff_sel),
    .multi   (multi),
    .empty   (empty),
    .res     (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst)           res_q <= '0;
    else if (in_valid) res_q <= res_d;
    else               res_q <= '0;
  end

  assign rd_stb  = res_q.rd;
  assign wr_stb  = res_q.wr;
  assign trap    = res_q.trap;
  assign sel     = res_q.sel;
  assign to_int  = res_q.to_int;
  assign is_areg = res_q.areg;
  assign reg_num = res_q.num;

  a_r12_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_stb, wr_stb, trap}));

  a_r12_quiet_fields: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb || wr_stb) |-> (sel == '0 && !to_int && !is_areg && reg_num == '0));

  a_r2_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb || trap) |-> $past(in_valid));

  a_r3_single_sel: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> ($countones(sel) == 1));

  a_r4_direction: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> (to_int == rd_stb));

  a_r8_areg_iaddr_only: assert property (@(posedge clk) disable iff (rst)
    ((rd_stb || wr_stb) && is_areg) |-> (sel == 3'b001));
endmodule

// File: tb/test_fpu_ctl_xfer_dec.sv
`timescale 1ns/1ps
module test_fpu_ctl_xfer_dec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic [15:0] ext_word = '0;
  logic        late_model = 1'b0;
  logic        rd_stb, wr_stb, trap, to_int, is_areg;
  logic [2:0]  sel, reg_num;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpu_ctl_xfer_dec i_fpu_ctl_xfer_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .ext_word(ext_word), .late_model(late_model), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .trap(trap), .sel(sel), .to_int(to_int),
    .is_areg(is_areg), .reg_num(reg_num)
  );

  // {rd, wr, trap, sel[2:0], to_int, areg, num[2:0]}
  localparam logic [10:0] NOTHING = 11'd0;
  localparam logic [10:0] TRAPPED = 11'b001_000_0_0_000;

  function automatic logic [10:0] xf(bit rd, logic [2:0] s, bit ar, logic [2:0] n);
    return {rd, !rd, 1'b0, s, rd, ar, n};
  endfunction

  function automatic logic [15:0] op(logic [2:0] mode, logic [2:0] n);
    return 16'hF200 | {10'd0, mode, n};
  endfunction

  function automatic logic [15:0] ex(logic [1:0] cls, bit dir, logic [2:0] s);
    return {cls, dir, s, 10'd0};
  endfunction

  task automatic chk(string tag, logic [10:0] exp);
    logic [10:0] act;
    act = {rd_stb, wr_stb, trap, sel, to_int, is_areg, reg_num};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive one instruction; returns at the negedge where its result is visible
  task automatic send(logic [15:0] o, logic [15:0] e, bit late);
    @(negedge clk);
    opcode = o; ext_word = e; late_model = late; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 outputs during reset", NOTHING);
    @(negedge clk); rst = 1'b0;
    chk("R1 outputs after reset", NOTHING);
  endtask

  task automatic t_dreg_single();
    send(op(3'b000, 3'd3), ex(2'b10, 1, 3'b100), 0);
    chk("R3 R4 read control to D3", xf(1, 3'b100, 0, 3'd3));
    send(op(3'b000, 3'd5), ex(2'b10, 0, 3'b010), 0);
    chk("R3 R4 write status from D5", xf(0, 3'b010, 0, 3'd5));
    send(op(3'b000, 3'd0), ex(2'b10, 1, 3'b001), 1);
    chk("R3 read iaddr to D0 late", xf(1, 3'b001, 0, 3'd0));
  endtask

  task automatic t_pulse();
    send(op(3'b000, 3'd7), ex(2'b10, 0, 3'b100), 0);
    chk("R2 result one cycle after valid", xf(0, 3'b100, 0, 3'd7));
    @(negedge clk);
    chk("R2 pulse lasts one cycle", NOTHING);
    opcode = op(3'b000, 3'd1); ext_word = ex(2'b10, 1, 3'b100);
    @(negedge clk); @(negedge clk);
    chk("R2 no output without valid", NOTHING);
  endtask

  task automatic t_empty_dreg();
    send(op(3'b000, 3'd2), ex(2'b10, 1, 3'b000), 0);
    chk("R5 empty selection reads iaddr", xf(1, 3'b001, 0, 3'd2));
    send(op(3'b000, 3'd6), ex(2'b10, 0, 3'b000), 1);
    chk("R5 empty selection writes iaddr late", xf(0, 3'b001, 0, 3'd6));
  endtask

  task automatic t_dreg_multi();
    send(op(3'b000, 3'd1), ex(2'b10, 1, 3'b110), 0);
    chk("R6 multi select traps", TRAPPED);
    send(op(3'b000, 3'd1), ex(2'b10, 0, 3'b111), 0);
    chk("R6 all three select traps", TRAPPED);
    send(op(3'b000, 3'd1), ex(2'b10, 1, 3'b101), 1);
    chk("R7 multi select late is silent", NOTHING);
  endtask

  task automatic t_areg();
    send(op(3'b001, 3'd4), ex(2'b10, 1, 3'b001), 0);
    chk("R8 iaddr to A4", xf(1, 3'b001, 1, 3'd4));
    send(op(3'b001, 3'd2), ex(2'b10, 0, 3'b010), 0);
    chk("R8 status with A reg traps", TRAPPED);
    send(op(3'b001, 3'd2), ex(2'b10, 1, 3'b101), 1);
    chk("R8 control with A reg traps late", TRAPPED);
  endtask

  task automatic t_areg_empty();
    send(op(3'b001, 3'd5), ex(2'b10, 0, 3'b000), 0);
    chk("R9 empty A reg default writes iaddr", xf(0, 3'b001, 1, 3'd5));
    send(op(3'b001, 3'd5), ex(2'b10, 1, 3'b000), 1);
    chk("R9 empty A reg late traps", TRAPPED);
  endtask

  task automatic t_list();
    send(op(3'b011, 3'd0), ex(2'b11, 1, 3'b000), 0);
    chk("R10 list store postincrement traps", TRAPPED);
    send(op(3'b100, 3'd0), ex(2'b11, 0, 3'b000), 1);
    chk("R10 list load predecrement traps", TRAPPED);
    send(op(3'b100, 3'd3), ex(2'b11, 1, 3'b000), 0);
    chk("R10 list store predecrement legal", NOTHING);
    send(op(3'b011, 3'd3), ex(2'b11, 0, 3'b000), 0);
    chk("R10 list load postincrement legal", NOTHING);
  endtask

  task automatic t_other();
    send(op(3'b010, 3'd1), ex(2'b10, 1, 3'b100), 0);
    chk("R13 memory mode control move silent", NOTHING);
    send(op(3'b000, 3'd1), ex(2'b00, 1, 3'b100), 0);
    chk("R13 other class silent", NOTHING);
  endtask

  task automatic t_model_sample();
    @(negedge clk);
    opcode = op(3'b000, 3'd1); ext_word = ex(2'b10, 1, 3'b011);
    late_model = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1 late_model = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R11 late sampled with valid", NOTHING);
    @(negedge clk);
    opcode = op(3'b001, 3'd1); ext_word = ex(2'b10, 1, 3'b000);
    late_model = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1 late_model = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R11 default sampled with valid", xf(1, 3'b001, 1, 3'd1));
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_dreg_single();
    t_pulse();
    t_empty_dreg();
    t_dreg_multi();
    t_areg();
    t_areg_empty();
    t_list();
    t_other();
    t_model_sample();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule